// File: doc/BRIEF.md
# Endpoint FIFO RAM Address Mapper

This block turns byte accesses from a USB packet engine into addresses inside one shared packet RAM. Endpoint 0 owns the first 64 bytes of that RAM permanently. Each of endpoints 1 to 15 gets a region placed by firmware, one per direction. A region is described by a start position in 8-byte units, a maximum packet size, and a flag that selects one buffer or two. A double-buffered region holds two packet halves, so one half can be filled while the other is drained.

Every access names an endpoint, a direction and an operation. The operation is packet start, data byte or packet done. The block keeps a byte pointer for each buffer and a write half and a read half for each double-buffered region. It also tracks a full bit for each half. From these it drives the RAM address and write enable and reports whether the buffer is full or empty. A Tx endpoint may be set to use the Rx region of the same number. Only one direction may then run a packet at a time: an access from the other direction is refused, and a sticky conflict flag records it. A configuration that is too small, that reaches into the endpoint 0 area or that runs past the end of RAM raises an error flag. No data is written through such a configuration.

Top module: `ep_fifo_mapper`

## Requirements
- R1: Endpoint 0 always maps to RAM bytes 0 to 63 as a single 64-byte buffer at base 0. Configuration writes that name endpoint 0 change nothing and never raise `cfg_err_o`.
- R2: For an enabled endpoint of 1 to 15, `ram_addr_o` = start*8 + (active half ? max_packet : 0) + byte pointer. The active half is the write half when `acc_wr_i`=1 and the read half when `acc_wr_i`=0.
- R3: A packet start (`acc_op_i`=1) resets the byte pointer to 0. Each data byte (`acc_op_i`=0) advances it by one. After byte max_packet-1 it wraps to 0. Op code 3 is idle.
- R4: A packet done (`acc_op_i`=2) resets the pointer. With `acc_wr_i`=1 it sets the full bit of the write half; with `acc_wr_i`=0 it clears the full bit of the read half. In double-buffer mode the done also toggles that half. In single-buffer mode both halves stay at 0.
- R5: `buf_full_o` shows the full bit of the write half. `buf_empty_o` shows the inverse of the full bit of the read half. A data-byte write to a full half gives `ram_we_o`=0 and leaves the pointer unchanged.
- R6: `cfg_err_o` is 1 while any enabled region has max_packet < 8, start < 8 units (bytes 0 to 63), or start*8 + size > 2^RAM_AW. Size is max_packet, or twice that when double buffering is on. Accesses through an errored or disabled endpoint never write.
- R7: With the share bit set for an endpoint number, its Tx direction (`acc_dir_i`=1) uses the Rx region (`acc_dir_i`=0) and that region's pointer and halves.
- R8: On a shared region, once one direction has started a packet, every access from the other direction before the done is refused with no write. The refusal sets `conflict_o`, which stays set until reset.
- R9: After reset all pointers and halves are 0, every buffer is empty, and `cfg_err_o` and `conflict_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_ep_i | input | 4 | Endpoint number being configured |
| cfg_dir_i | input | 1 | Direction being configured, 0 Rx, 1 Tx |
| cfg_en_i | input | 1 | Region enable |
| cfg_start_i | input | RAM_AW-3 | Region start in 8-byte units |
| cfg_mps_i | input | MPS_W | Maximum packet size in bytes |
| cfg_dbl_i | input | 1 | Double-buffer enable |
| cfg_share_i | input | 1 | Tx uses the Rx region of this endpoint number |
| acc_valid_i | input | 1 | Access strobe |
| acc_ep_i | input | 4 | Accessed endpoint number |
| acc_dir_i | input | 1 | Accessed direction, 0 Rx, 1 Tx |
| acc_op_i | input | 2 | 0 byte, 1 packet start, 2 packet done, 3 idle |
| acc_wr_i | input | 1 | 1 fills the buffer, 0 drains it |
| ram_addr_o | output | RAM_AW | Packet RAM byte address |
| ram_we_o | output | 1 | Packet RAM write enable |
| buf_full_o | output | 1 | Write half of the addressed buffer is full |
| buf_empty_o | output | 1 | Read half of the addressed buffer is empty |
| cfg_err_o | output | 1 | An enabled region is illegal |
| conflict_o | output | 1 | Sticky shared-region conflict |

## Verification
The assertions check on every cycle that endpoint 0 addresses stay below 64 and that no write enable reaches a full half. They also check that a packet start clears its pointer, that a write-side done leaves a half marked full, and that a refused access keeps the owning direction and holds the conflict flag. The exact address arithmetic cannot be shown by assertions, and neither can the half toggling across a packet sequence. The same holds for the boundary cases of the error check, with a region ending exactly at the top of RAM allowed and one byte more refused. The bench's scenarios and vector walk show these.

// File: rtl/ep_map_pkg.sv
package ep_map_pkg;
  typedef enum logic [1:0] {
    OP_BYTE  = 2'd0,
    OP_START = 2'd1,
    OP_DONE  = 2'd2,
    OP_IDLE  = 2'd3
  } acc_op_e;

  localparam int unsigned EP0_BYTES = 64;
  localparam int unsigned MIN_BYTES = 8;
endpackage

// File: rtl/ep_cfg_regs.sv
module ep_cfg_regs
  import ep_map_pkg::*;
#(
  parameter int unsigned EP_CNT = 16,
  parameter int unsigned RAM_AW = 13,
  parameter int unsigned MPS_W  = 11,
  localparam int unsigned EPW   = $clog2(EP_CNT),
  localparam int unsigned SLOTS = 2 * EP_CNT,
  localparam int unsigned SLW   = $clog2(SLOTS),
  localparam int unsigned SUW   = RAM_AW - 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [EPW-1:0]   wr_ep_i,
  input  logic             wr_dir_i,
  input  logic             wr_en_i,
  input  logic [SUW-1:0]   wr_start_i,
  input  logic [MPS_W-1:0] wr_mps_i,
  input  logic             wr_dbl_i,
  input  logic             wr_share_i,
  input  logic [EPW-1:0]   rd_ep_i,
  input  logic             rd_dir_i,
  output logic [SLW-1:0]   rd_slot_o,
  output logic             rd_ok_o,
  output logic [RAM_AW-1:0] rd_base_o,
  output logic [MPS_W-1:0] rd_mps_o,
  output logic             rd_dbl_o,
  output logic             rd_share_o,
  output logic             err_o
);
  localparam int unsigned EW = RAM_AW + MPS_W + 2;
  localparam logic [EW-1:0] RAM_LIM = EW'(1) << RAM_AW;
  localparam logic [SUW-1:0] EP0_UNITS = SUW'(EP0_BYTES / 8);

  logic             en_q    [SLOTS];
  logic [SUW-1:0]   start_q [SLOTS];
  logic [MPS_W-1:0] mps_q   [SLOTS];
  logic             dbl_q   [SLOTS];
  logic             err_q   [SLOTS];
  logic             share_q [EP_CNT];

  logic [SLW-1:0] wr_slot;
  logic [EW-1:0]  wr_size, wr_end;
  logic           wr_bad;

  assign wr_slot = {wr_ep_i, wr_dir_i};
  assign wr_size = wr_dbl_i ? (EW'(wr_mps_i) << 1) : EW'(wr_mps_i);
  assign wr_end  = (EW'(wr_start_i) << 3) + wr_size;
  assign wr_bad  = wr_en_i && ((wr_mps_i < MPS_W'(MIN_BYTES)) ||
                               (wr_start_i < EP0_UNITS) || (wr_end > RAM_LIM));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < int'(SLOTS); s++) begin
        en_q[s]    <= 1'b0;
        start_q[s] <= '0;
        mps_q[s]   <= '0;
        dbl_q[s]   <= 1'b0;
        err_q[s]   <= 1'b0;
      end
      for (int e = 0; e < int'(EP_CNT); e++) share_q[e] <= 1'b0;
    end else if (wr_i && (wr_ep_i != '0)) begin
      en_q[wr_slot]    <= wr_en_i;
      start_q[wr_slot] <= wr_start_i;
      mps_q[wr_slot]   <= wr_mps_i;
      dbl_q[wr_slot]   <= wr_dbl_i;
      err_q[wr_slot]   <= wr_bad;
      share_q[wr_ep_i] <= wr_share_i;
    end
  end

  logic ep0;
  assign ep0 = (rd_ep_i == '0);

  always_comb begin
    rd_share_o = ep0 ? 1'b1 : share_q[rd_ep_i];
    rd_slot_o  = rd_share_o ? {rd_ep_i, 1'b0} : {rd_ep_i, rd_dir_i};
    if (ep0) begin
      rd_ok_o   = 1'b1;
      rd_base_o = '0;
      rd_mps_o  = MPS_W'(EP0_BYTES);
      rd_dbl_o  = 1'b0;
    end else begin
      rd_ok_o   = en_q[rd_slot_o] && !err_q[rd_slot_o];
      rd_base_o = RAM_AW'(start_q[rd_slot_o]) << 3;
      rd_mps_o  = mps_q[rd_slot_o];
      rd_dbl_o  = dbl_q[rd_slot_o];
    end
  end

  always_comb begin
    err_o = 1'b0;
    for (int s = 0; s < int'(SLOTS); s++) err_o = err_o | (en_q[s] & err_q[s]);
  end

  // R1
  ep0_fixed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ep_i == '0) |-> (rd_base_o == '0 && rd_ok_o && !rd_dbl_o));
endmodule

// File: rtl/ep_buf_state.sv
module ep_buf_state
  import ep_map_pkg::*;
#(
  parameter int unsigned SLOTS = 32,
  parameter int unsigned MPS_W = 11,
  localparam int unsigned SLW  = $clog2(SLOTS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SLW-1:0]   slot_i,
  input  logic [MPS_W-1:0] mps_i,
  input  logic             dbl_i,
  input  acc_op_e          op_i,
  input  logic             wr_i,
  input  logic             go_i,
  input  logic             clr_i,
  input  logic [SLW-1:0]   clr_slot_i,
  output logic [MPS_W-1:0] ptr_o,
  output logic             half_o,
  output logic             full_wr_o,
  output logic             full_rd_o
);
  logic [MPS_W-1:0] ptr_q   [SLOTS];
  logic             whalf_q [SLOTS];
  logic             rhalf_q [SLOTS];
  logic [1:0]       full_q  [SLOTS];

  logic [MPS_W-1:0] ptr_nxt;
  logic             step;

  assign ptr_o     = ptr_q[slot_i];
  assign half_o    = wr_i ? whalf_q[slot_i] : rhalf_q[slot_i];
  assign full_wr_o = full_q[slot_i][whalf_q[slot_i]];
  assign full_rd_o = full_q[slot_i][rhalf_q[slot_i]];
  assign ptr_nxt   = (ptr_o == mps_i - MPS_W'(1)) ? '0 : ptr_o + MPS_W'(1);
  assign step      = !(wr_i && full_wr_o);

  for (genvar s = 0; s < int'(SLOTS); s++) begin : g_slot
    logic sel, wipe;
    assign sel  = go_i && (slot_i == SLW'(s));
    assign wipe = clr_i && (clr_slot_i == SLW'(s));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ptr_q[s]   <= '0;
        whalf_q[s] <= 1'b0;
        rhalf_q[s] <= 1'b0;
        full_q[s]  <= 2'b00;
      end else if (wipe) begin
        ptr_q[s]   <= '0;
        whalf_q[s] <= 1'b0;
        rhalf_q[s] <= 1'b0;
        full_q[s]  <= 2'b00;
      end else if (sel) begin
        unique case (op_i)
          OP_BYTE:  if (step) ptr_q[s] <= ptr_nxt;
          OP_START: ptr_q[s] <= '0;
          OP_DONE: begin
            ptr_q[s] <= '0;
            if (wr_i) begin
              full_q[s][whalf_q[s]] <= 1'b1;
              if (dbl_i) whalf_q[s] <= !whalf_q[s];
            end else begin
              full_q[s][rhalf_q[s]] <= 1'b0;
              if (dbl_i) rhalf_q[s] <= !rhalf_q[s];
            end
          end
          default: ;
        endcase
      end
    end

    // R3
    start_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel && !wipe && op_i == OP_START) |=> (ptr_q[s] == '0));
    // R4
    done_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel && !wipe && op_i == OP_DONE && wr_i) |=> (full_q[s] != 2'b00));
    // R4
    single_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel && !wipe && !dbl_i && !whalf_q[s] && !rhalf_q[s]) |=> (!whalf_q[s] && !rhalf_q[s]));
  end
endmodule

// File: rtl/ep_share_guard.sv
module ep_share_guard
  import ep_map_pkg::*;
#(
  parameter int unsigned EP_CNT = 16,
  localparam int unsigned EPW  = $clog2(EP_CNT)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           valid_i,
  input  logic [EPW-1:0] ep_i,
  input  logic           dir_i,
  input  acc_op_e        op_i,
  input  logic           share_i,
  output logic           block_o,
  output logic           conflict_o
);
  logic busy_q  [EP_CNT];
  logic owner_q [EP_CNT];
  logic conflict_q;

  assign block_o    = valid_i && share_i && busy_q[ep_i] && (owner_q[ep_i] != dir_i);
  assign conflict_o = conflict_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < int'(EP_CNT); e++) begin
        busy_q[e]  <= 1'b0;
        owner_q[e] <= 1'b0;
      end
      conflict_q <= 1'b0;
    end else if (block_o) begin
      conflict_q <= 1'b1;
    end else if (valid_i && share_i) begin
      if (op_i == OP_START) begin
        busy_q[ep_i]  <= 1'b1;
        owner_q[ep_i] <= dir_i;
      end else if (op_i == OP_DONE) begin
        busy_q[ep_i] <= 1'b0;
      end
    end
  end

  // R8
  conflict_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conflict_o |=> conflict_o);

  for (genvar e = 0; e < int'(EP_CNT); e++) begin : g_ep
    // R8
    owner_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (block_o && ep_i == EPW'(e)) |=> (busy_q[e] && owner_q[e] == $past(owner_q[e])));
  end
endmodule

// File: rtl/ep_fifo_mapper.sv
module ep_fifo_mapper
  import ep_map_pkg::*;
#(
  parameter int unsigned EP_CNT = 16,
  parameter int unsigned RAM_AW = 13,
  parameter int unsigned MPS_W  = 11,
  localparam int unsigned EPW   = $clog2(EP_CNT),
  localparam int unsigned SLOTS = 2 * EP_CNT,
  localparam int unsigned SLW   = $clog2(SLOTS),
  localparam int unsigned SUW   = RAM_AW - 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [EPW-1:0]    cfg_ep_i,
  input  logic              cfg_dir_i,
  input  logic              cfg_en_i,
  input  logic [SUW-1:0]    cfg_start_i,
  input  logic [MPS_W-1:0]  cfg_mps_i,
  input  logic              cfg_dbl_i,
  input  logic              cfg_share_i,
  input  logic              acc_valid_i,
  input  logic [EPW-1:0]    acc_ep_i,
  input  logic              acc_dir_i,
  input  logic [1:0]        acc_op_i,
  input  logic              acc_wr_i,
  output logic [RAM_AW-1:0] ram_addr_o,
  output logic              ram_we_o,
  output logic              buf_full_o,
  output logic              buf_empty_o,
  output logic              cfg_err_o,
  output logic              conflict_o
);
  acc_op_e          op;
  logic [SLW-1:0]   slot;
  logic             ok, dbl, share, block, go, half, full_wr, full_rd;
  logic [RAM_AW-1:0] base;
  logic [MPS_W-1:0] mps, ptr;

  assign op = acc_op_e'(acc_op_i);

  ep_cfg_regs #(.EP_CNT(EP_CNT), .RAM_AW(RAM_AW), .MPS_W(MPS_W)) u_cfg (
    .clk_i, .rst_ni,
    .wr_i(cfg_we_i), .wr_ep_i(cfg_ep_i), .wr_dir_i(cfg_dir_i), .wr_en_i(cfg_en_i),
    .wr_start_i(cfg_start_i), .wr_mps_i(cfg_mps_i), .wr_dbl_i(cfg_dbl_i),
    .wr_share_i(cfg_share_i), .rd_ep_i(acc_ep_i), .rd_dir_i(acc_dir_i),
    .rd_slot_o(slot), .rd_ok_o(ok), .rd_base_o(base), .rd_mps_o(mps),
    .rd_dbl_o(dbl), .rd_share_o(share), .err_o(cfg_err_o)
  );

  ep_share_guard #(.EP_CNT(EP_CNT)) u_guard (
    .clk_i, .rst_ni,
    .valid_i(acc_valid_i && ok), .ep_i(acc_ep_i), .dir_i(acc_dir_i), .op_i(op),
    .share_i(share), .block_o(block), .conflict_o(conflict_o)
  );

  assign go = acc_valid_i && ok && !block;

  ep_buf_state #(.SLOTS(SLOTS), .MPS_W(MPS_W)) u_buf (
    .clk_i, .rst_ni,
    .slot_i(slot), .mps_i(mps), .dbl_i(dbl), .op_i(op), .wr_i(acc_wr_i), .go_i(go),
    .clr_i(cfg_we_i && cfg_ep_i != '0), .clr_slot_i({cfg_ep_i, cfg_dir_i}),
    .ptr_o(ptr), .half_o(half), .full_wr_o(full_wr), .full_rd_o(full_rd)
  );

  assign ram_addr_o  = base + (half ? RAM_AW'(mps) : '0) + RAM_AW'(ptr);
  assign ram_we_o    = go && (op == OP_BYTE) && acc_wr_i && !full_wr;
  assign buf_full_o  = full_wr;
  assign buf_empty_o = !full_rd;

  // R1
  ep0_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && acc_ep_i == '0) |-> (ram_addr_o < RAM_AW'(EP0_BYTES)));
  // R5
  no_full_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> !buf_full_o);
endmodule

// File: tb/ep_fifo_mapper_bench.sv
module ep_fifo_mapper_bench;
  localparam int CLK_NS = 10;
  localparam int RAM_AW = 13;
  localparam int MPS_W  = 11;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cfg_we = 0, cfg_dir = 0, cfg_en = 0, cfg_dbl = 0, cfg_share = 0;
  logic [3:0] cfg_ep = 0;
  logic [RAM_AW-4:0] cfg_start = 0;
  logic [MPS_W-1:0] cfg_mps = 0;
  logic acc_valid = 0, acc_dir = 0, acc_wr = 0;
  logic [3:0] acc_ep = 0;
  logic [1:0] acc_op = 2'd3;
  logic [RAM_AW-1:0] ram_addr;
  logic ram_we, buf_full, buf_empty, cfg_err, conflict;

  int total = 0, fails = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  ep_fifo_mapper #(.EP_CNT(16), .RAM_AW(RAM_AW), .MPS_W(MPS_W)) u_ep_fifo_mapper (
    .clk_i(clk), .rst_ni,
    .cfg_we_i(cfg_we), .cfg_ep_i(cfg_ep), .cfg_dir_i(cfg_dir), .cfg_en_i(cfg_en),
    .cfg_start_i(cfg_start), .cfg_mps_i(cfg_mps), .cfg_dbl_i(cfg_dbl), .cfg_share_i(cfg_share),
    .acc_valid_i(acc_valid), .acc_ep_i(acc_ep), .acc_dir_i(acc_dir), .acc_op_i(acc_op),
    .acc_wr_i(acc_wr), .ram_addr_o(ram_addr), .ram_we_o(ram_we), .buf_full_o(buf_full),
    .buf_empty_o(buf_empty), .cfg_err_o(cfg_err), .conflict_o(conflict)
  );

  // {op, wr, exp_we, exp_addr, exp_full, exp_empty}; ep1 Rx, base 128, mps 8, double
  localparam int VW = 19;
  localparam logic [VW-1:0] VEC [15] = '{
    {2'd1, 1'b1, 1'b0, 13'd128, 1'b0, 1'b1},
    {2'd0, 1'b1, 1'b1, 13'd128, 1'b0, 1'b1},
    {2'd0, 1'b1, 1'b1, 13'd129, 1'b0, 1'b1},
    {2'd2, 1'b1, 1'b0, 13'd130, 1'b0, 1'b1},
    {2'd0, 1'b1, 1'b1, 13'd136, 1'b0, 1'b0},
    {2'd0, 1'b1, 1'b1, 13'd137, 1'b0, 1'b0},
    {2'd2, 1'b1, 1'b0, 13'd138, 1'b0, 1'b0},
    {2'd0, 1'b1, 1'b0, 13'd128, 1'b1, 1'b0},
    {2'd1, 1'b0, 1'b0, 13'd128, 1'b1, 1'b0},
    {2'd0, 1'b0, 1'b0, 13'd128, 1'b1, 1'b0},
    {2'd0, 1'b0, 1'b0, 13'd129, 1'b1, 1'b0},
    {2'd2, 1'b0, 1'b0, 13'd130, 1'b1, 1'b0},
    {2'd0, 1'b1, 1'b1, 13'd128, 1'b0, 1'b0},
    {2'd2, 1'b0, 1'b0, 13'd137, 1'b0, 1'b0},
    {2'd0, 1'b1, 1'b1, 13'd128, 1'b0, 1'b1}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfg(input int ep, input bit dir, input bit en, input int start,
                     input int mps, input bit dbl, input bit share);
    @(negedge clk);
    acc_valid = 0; acc_op = 2'd3;
    cfg_we = 1; cfg_ep = 4'(ep); cfg_dir = dir; cfg_en = en;
    cfg_start = 10'(start); cfg_mps = 11'(mps); cfg_dbl = dbl; cfg_share = share;
    @(posedge clk);
    #1 cfg_we = 0;
  endtask

  task automatic drive(input int ep, input bit dir, input int op, input bit wr);
    @(negedge clk);
    acc_valid = 1; acc_ep = 4'(ep); acc_dir = dir; acc_op = 2'(op); acc_wr = wr;
    #2;
  endtask

  task automatic idle();
    @(negedge clk);
    acc_valid = 0; acc_op = 2'd3;
    #2;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_ni = 1;
    idle();
    // R9 reset state
    chk("R9 cfg_err", cfg_err, 0);
    chk("R9 conflict", conflict, 0);
    chk("R9 empty", buf_empty, 1);
    chk("R9 full", buf_full, 0);

    // R1 / R3 ep0 pointer walk and wrap
    drive(0, 0, 1, 1);
    chk("R1 ep0 start addr", ram_addr, 0);
    for (int i = 0; i < 65; i++) begin
      drive(0, 0, 0, 1);
      chk("R3 ep0 byte addr", ram_addr, i % 64);
      chk("R1 ep0 we", ram_we, 1);
    end
    drive(0, 0, 1, 1);
    cfg(0, 0, 1, 100, 2, 0, 0);
    idle();
    chk("R1 ep0 cfg ignored err", cfg_err, 0);
    drive(0, 0, 0, 1);
    chk("R1 ep0 addr after cfg", ram_addr, 0);
    chk("R1 ep0 we after cfg", ram_we, 1);
    drive(0, 0, 1, 1);

    // R2 R4 R5 vector walk on ep1
    cfg(1, 0, 1, 16, 8, 1, 0);
    idle();
    chk("R6 legal ep1", cfg_err, 0);
    for (int v = 0; v < 15; v++) begin
      drive(1, 0, int'(VEC[v][18:17]), VEC[v][16]);
      chk($sformatf("R2 addr v%0d", v), ram_addr, int'(VEC[v][14:2]));
      chk($sformatf("R5 we v%0d", v), ram_we, VEC[v][15]);
      chk($sformatf("R4 full v%0d", v), buf_full, VEC[v][1]);
      chk($sformatf("R4 empty v%0d", v), buf_empty, VEC[v][0]);
    end

    // R6 error cases
    cfg(2, 0, 1, 32, 4, 0, 0);
    idle();
    chk("R6 small mps err", cfg_err, 1);
    drive(2, 0, 0, 1);
    chk("R6 errored no write", ram_we, 0);
    cfg(2, 0, 0, 32, 4, 0, 0);
    idle();
    chk("R6 disable clears err", cfg_err, 0);
    drive(2, 0, 0, 1);
    chk("R6 disabled no write", ram_we, 0);
    cfg(3, 1, 1, 4, 16, 0, 0);
    idle();
    chk("R6 ep0 overlap err", cfg_err, 1);
    cfg(3, 1, 0, 4, 16, 0, 0);
    cfg(5, 1, 1, 1020, 32, 0, 0);
    idle();
    chk("R6 exact top ok", cfg_err, 0);
    drive(5, 1, 0, 1);
    chk("R2 top addr", ram_addr, 8160);
    chk("R2 top we", ram_we, 1);
    cfg(5, 1, 1, 1020, 32, 1, 0);
    idle();
    chk("R6 past end err", cfg_err, 1);
    cfg(5, 1, 0, 1020, 32, 1, 0);
    idle();
    chk("R6 cleared", cfg_err, 0);

    // R7 R8 sharing on ep4
    cfg(4, 0, 1, 64, 16, 0, 1);
    drive(4, 1, 0, 1);
    chk("R7 tx uses rx region", ram_addr, 512);
    chk("R7 tx we", ram_we, 1);
    drive(4, 0, 1, 1);
    chk("R8 no conflict yet", conflict, 0);
    drive(4, 1, 1, 0);
    drive(4, 1, 0, 1);
    chk("R8 conflict set", conflict, 1);
    chk("R8 blocked no write", ram_we, 0);
    drive(4, 0, 2, 0);
    drive(4, 1, 0, 1);
    chk("R8 after done write", ram_we, 1);
    chk("R8 after done addr", ram_addr, 512);
    chk("R8 sticky", conflict, 1);
    idle();

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule